// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of token latches that two independent ports, called left and right, use to claim and hand back shared resources. It is separate from any shared data memory. A port reaches the bank through its own semaphore select while its memory chip enable is held inactive. It picks one latch with a short index and either writes a single request/release bit or reads back the latch as that port sees it.

Ownership is shown differently on each side. The holder of a token reads 0 and the opposite port reads 1. A free token reads 1 on both sides. When a port asks for a token that the other side holds, the request is kept. The token then passes to that port in the cycle its holder releases it, so the waiting side only polls until it reads 0. If both ports ask for the same free token in the same cycle, the left port wins and the right request stays queued. A read is captured into a per-port output register, and every data bit carries the latch value.

Top module: `semaphore_bank`

## Requirements
- R1: After reset no token is held, no request is queued, and both data outputs read all ones.
- R2: Only data-in bit 0 is used on a write: 0 records a request for the addressed token and 1 withdraws that port's request or releases its token.
- R3: A request to a free token with no competing request makes the requester the owner from the next clock. The owner then reads 0 at that index and the other port reads 1.
- R4: A port that does not own a token cannot change its ownership. Its writes only set or clear its own queued request.
- R5: A request queued while the other port holds the token is granted in the clock edge at which the holder writes 1.
- R6: When neither port holds a token, both ports read 1 at its index.
- R7: A read (select, output enable, write enable low) loads the latch value as seen by that port into every one of the DW output bits. The value appears one clock after the read cycle.
- R8: The output word holds its value until the next read on the same port. A write by the other port in the read cycle does not alter the captured value.
- R9: While a port's memory chip enable is active, its semaphore select is ignored: no request changes and the output register holds.
- R10: If both ports request the same free token in the same cycle, the left port becomes the owner and the right request stays queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left semaphore select, active high |
| l_ce | input | 1 | Left memory chip enable, active high; blocks semaphore access |
| l_we | input | 1 | Left write enable |
| l_oe | input | 1 | Left output enable |
| l_addr | input | IW (3) | Left token index |
| l_din | input | 1 | Left write bit (0 request, 1 release) |
| l_dout | output | DW (16) | Left captured read word |
| r_sel | input | 1 | Right semaphore select, active high |
| r_ce | input | 1 | Right memory chip enable, active high; blocks semaphore access |
| r_we | input | 1 | Right write enable |
| r_oe | input | 1 | Right output enable |
| r_addr | input | IW (3) | Right token index |
| r_din | input | 1 | Right write bit (0 request, 1 release) |
| r_dout | output | DW (16) | Right captured read word |

## Verification
Two pairs of events can land in one cycle. The first is a read on one port together with a write on the other port to the same token. The bench provokes this by having the right port read a token while the left owner releases it to the queued right request. It judges the result by the right output, which must still show the pre-release 1, and by a read one cycle later, which must show 0. The second pair is a request from each port for the same free token in the same cycle. The bench judges it by reading both sides afterwards: the left side must read 0 and the right side 1, and a later left release must pass the token to the right.

// File: rtl/semaphore_bank.sv
module semaphore_bank #(
  parameter int NSEM = 8,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NSEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_ce,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [IW-1:0] l_addr,
  input  logic          l_din,
  output logic [DW-1:0] l_dout,
  input  logic          r_sel,
  input  logic          r_ce,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [IW-1:0] r_addr,
  input  logic          r_din,
  output logic [DW-1:0] r_dout
);

  logic [NSEM-1:0] lreq, rreq, own_l, own_r;
  logic [NSEM-1:0] lreq_n, rreq_n, own_l_n, own_r_n;

  wire l_acc = l_sel & ~l_ce;
  wire r_acc = r_sel & ~r_ce;
  wire l_wr  = l_acc & l_we;
  wire r_wr  = r_acc & r_we;
  wire l_rd  = l_acc & l_oe & ~l_we;
  wire r_rd  = r_acc & r_oe & ~r_we;

  always_comb begin
    lreq_n = lreq;
    rreq_n = rreq;
    if (l_wr) lreq_n[l_addr] = ~l_din;
    if (r_wr) rreq_n[r_addr] = ~r_din;
    for (int i = 0; i < NSEM; i++) begin
      own_l_n[i] = own_l[i] & lreq_n[i];
      own_r_n[i] = own_r[i] & rreq_n[i];
      if (!own_l_n[i] && !own_r_n[i]) begin
        if (lreq_n[i])      own_l_n[i] = 1'b1;
        else if (rreq_n[i]) own_r_n[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lreq   <= '0;
      rreq   <= '0;
      own_l  <= '0;
      own_r  <= '0;
      l_dout <= '1;
      r_dout <= '1;
    end else begin
      lreq  <= lreq_n;
      rreq  <= rreq_n;
      own_l <= own_l_n;
      own_r <= own_r_n;
      if (l_rd) l_dout <= {DW{~own_l[l_addr]}};
      if (r_rd) r_dout <= {DW{~own_r[r_addr]}};
    end
  end

  assert_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (l_dout == '0 || l_dout == '1) && (r_dout == '0 || r_dout == '1));
  assert_hold_l_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(l_dout));
  assert_hold_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd |=> $stable(r_dout));
  assert_ce_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce && !(r_sel && !r_ce)) |=> $stable(lreq) && $stable(rreq));

  for (genvar g = 0; g < NSEM; g++) begin : g_chk
    wire l_hit = l_wr && l_addr == IW'(g);
    wire r_hit = r_wr && r_addr == IW'(g);
    assert_keep_l_R4: assert property (@(posedge clk) disable iff (!rst_n)
      own_l[g] && !(l_hit && l_din) |=> own_l[g]);
    assert_keep_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
      own_r[g] && !(r_hit && r_din) |=> own_r[g]);
    assert_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !own_l[g] && !own_r[g] && !rreq[g] && l_hit && !l_din && !r_hit |=> own_l[g] && !own_r[g]);
    assert_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
      own_l[g] && rreq[g] && l_hit && l_din && !r_hit |=> own_r[g] && !own_l[g]);
    assert_tie_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !own_l[g] && !own_r[g] && l_hit && !l_din && r_hit && !r_din |=> own_l[g] && rreq[g]);
  end

endmodule

// File: tb/semaphore_bank_bench.sv
`timescale 1ns/1ps
module semaphore_bank_bench;
  localparam int DW = 16;
  localparam logic [DW-1:0] ONES = '1;
  localparam logic [DW-1:0] ZERO = '0;

  logic clk = 0, rst_n = 0;
  logic l_sel = 0, l_ce = 0, l_we = 0, l_oe = 0, l_din = 0;
  logic r_sel = 0, r_ce = 0, r_we = 0, r_oe = 0, r_din = 0;
  logic [2:0] l_addr = 0, r_addr = 0;
  logic [DW-1:0] l_dout, r_dout;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  semaphore_bank #(.NSEM(8), .DW(DW)) u_semaphore_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
    .r_sel(r_sel), .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout));

  // fields: lw laddr ldin | rw raddr rdin | check addr | exp left bit, exp right bit
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,3'd2,1'b0, 1'b0,3'd0,1'b0, 3'd2, 1'b0,1'b1},  // R3 grant
    {1'b0,3'd0,1'b0, 1'b1,3'd2,1'b0, 3'd2, 1'b0,1'b1},  // R4 queued, no takeover
    {1'b1,3'd2,1'b1, 1'b0,3'd0,1'b0, 3'd2, 1'b1,1'b0},  // R5 handoff
    {1'b0,3'd0,1'b0, 1'b1,3'd2,1'b1, 3'd2, 1'b1,1'b1},  // R6 free again
    {1'b1,3'd5,1'b0, 1'b1,3'd5,1'b0, 3'd5, 1'b0,1'b1},  // R10 tie
    {1'b1,3'd5,1'b1, 1'b0,3'd0,1'b0, 3'd5, 1'b1,1'b0},  // R10 queued right wins later
    {1'b0,3'd0,1'b0, 1'b1,3'd5,1'b1, 3'd5, 1'b1,1'b1},  // R6
    {1'b0,3'd0,1'b0, 1'b1,3'd7,1'b0, 3'd7, 1'b1,1'b0},  // R3 right grant
    {1'b1,3'd7,1'b1, 1'b0,3'd0,1'b0, 3'd7, 1'b1,1'b0},  // R4 non-owner release ignored
    {1'b0,3'd0,1'b0, 1'b1,3'd7,1'b1, 3'd7, 1'b1,1'b1},  // R2 release
    {1'b1,3'd0,1'b0, 1'b1,3'd1,1'b0, 3'd0, 1'b0,1'b1},  // R3 two indices at once
    {1'b0,3'd0,1'b0, 1'b0,3'd0,1'b0, 3'd1, 1'b1,1'b0},  // R3 other index
    {1'b0,3'd0,1'b0, 1'b1,3'd4,1'b0, 3'd4, 1'b1,1'b0},  // R3
    {1'b1,3'd4,1'b0, 1'b0,3'd0,1'b0, 3'd4, 1'b1,1'b0},  // R4 queue left
    {1'b1,3'd4,1'b1, 1'b0,3'd0,1'b0, 3'd4, 1'b1,1'b0},  // R2 cancel queued
    {1'b0,3'd0,1'b0, 1'b1,3'd4,1'b1, 3'd4, 1'b1,1'b1}   // R2 cancel held: token free
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ls, input logic lc, input logic lw, input logic lo, input logic [2:0] la, input logic ld,
                     input logic rs, input logic rc, input logic rw, input logic ro, input logic [2:0] ra, input logic rd);
    @(negedge clk);
    l_sel = ls; l_ce = lc; l_we = lw; l_oe = lo; l_addr = la; l_din = ld;
    r_sel = rs; r_ce = rc; r_we = rw; r_oe = ro; r_addr = ra; r_din = rd;
    @(negedge clk);
    l_sel = 0; l_ce = 0; l_we = 0; l_oe = 0; r_sel = 0; r_ce = 0; r_we = 0; r_oe = 0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset left word", l_dout, ONES);
    chk("R1 reset right word", r_dout, ONES);
    for (int i = 0; i < 8; i++) begin
      cyc(1,0,0,1,3'(i),0, 1,0,0,1,3'(i),0);
      chk("R1 left free after reset", l_dout, ONES);
      chk("R6 right free after reset", r_dout, ONES);
    end

    for (int v = 0; v < NV; v++) begin
      logic [14:0] e;
      e = VEC[v];
      cyc(e[14],0,e[14],0,e[13:11],e[10], e[9],0,e[9],0,e[8:6],e[5]);
      cyc(1,0,0,1,e[4:2],0, 1,0,0,1,e[4:2],0);
      chk($sformatf("R7 table %0d left", v), l_dout, {DW{e[1]}});
      chk($sformatf("R7 table %0d right", v), r_dout, {DW{e[0]}});
    end

    // R9: left write with chip enable active is ignored
    cyc(1,1,1,0,3'd3,0, 0,0,0,0,0,0);
    cyc(0,0,0,0,0,0, 1,0,1,0,3'd3,0);
    cyc(1,0,0,1,3'd3,0, 1,0,0,1,3'd3,0);
    chk("R9 blocked write left", l_dout, ONES);
    chk("R9 blocked write right owns", r_dout, ZERO);
    // R9: read with chip enable active leaves output held
    cyc(1,0,1,0,3'd6,0, 0,0,0,0,0,0);
    cyc(1,1,0,1,3'd6,0, 0,0,0,0,0,0);
    chk("R9 blocked read holds", l_dout, ONES);
    cyc(1,0,0,1,3'd6,0, 0,0,0,0,0,0);
    chk("R3 left owns 6", l_dout, ZERO);
    // R8: right reads while left hands 6 over in the same cycle
    cyc(0,0,0,0,0,0, 1,0,1,0,3'd6,0);
    cyc(1,0,1,0,3'd6,1, 1,0,0,1,3'd6,0);
    chk("R8 capture before handoff", r_dout, ONES);
    repeat (3) @(negedge clk);
    chk("R8 word held while idle", r_dout, ONES);
    chk("R8 left word held", l_dout, ZERO);
    cyc(0,0,0,0,0,0, 1,0,0,1,3'd6,0);
    chk("R5 right now owns 6", r_dout, ZERO);
    cyc(1,0,0,1,3'd6,0, 0,0,0,0,0,0);
    chk("R5 left sees 6 taken", l_dout, ONES);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule